// File: doc/BRIEF.md
# Multi-mode DMA channel engine

This block is one channel of a direct memory access engine. Software loads a start address, a transfer count and a control word through a small write port. The channel then issues one strobe per transfer on the cycles where it has work to do and the bus grant is high. Each strobe carries the current address. The peripheral request is interpreted in one of three ways. In single mode every request edge is worth one transfer. In block mode a request edge starts a burst that runs to the end. In demand mode the channel transfers for as long as the request is held.

After every transfer the address moves one step up or down and the remaining count drops by one. The transfer that empties the count raises terminal count, which ends the process. An external end-of-process input can end it earlier. When the process ends, the channel either reloads its current registers from the base copies and stays armed, or disables itself until software enables it again. Bus arbitration, the data movement and priority between channels belong to the surrounding logic.

Top module: `dma_chan_engine`

## Requirements
- R1: A write with `wr_sel`=0 loads both the base and the current address. A write with `wr_sel`=1 loads both the base and the current count. Both registers take the value in the same cycle, and `xfer_addr` shows the new current address from the next cycle on.
- R2: A write with `wr_sel`=2 loads the control word from `wr_data[4:0]`: bit 0 enable, bit 1 direction (1 = address counts down), bit 2 auto-reload, bits 4:3 mode (00 demand, 01 single, 10 block, 11 behaves as single).
- R3: `xfer_stb` is high only in cycles where the channel is enabled and `grant` is high. Each such cycle is one transfer at `xfer_addr`.
- R4: Each transfer decrements the current count by one and steps the current address by one, upward or downward as bit 1 selects, wrapping modulo 2^16.
- R5: `tc` is high together with the strobe of the transfer made while the current count is 1. A programmed count of N therefore gives exactly N transfers.
- R6: In single mode each rising edge of `req` gives exactly one transfer, however long `req` stays high. If the grant is low, the request is held pending until the grant arrives.
- R7: In block mode a rising edge of `req` starts a burst that transfers on every granted cycle, whatever `req` does, until end of process.
- R8: In demand mode a transfer happens on every cycle with both `req` and `grant` high. Dropping `req` pauses the run without losing the address or the count.
- R9: `eop_in` high while the channel is enabled ends the process. A transfer strobed in that same cycle still completes.
- R10: With auto-reload set, end of process copies the base address and base count into the current registers, and the channel stays enabled.
- R11: With auto-reload clear, end of process clears the enable. Requests then cause no transfer and leave the address untouched until the control word is written again.
- R12: After reset the channel is disabled, `xfer_addr` is 0, and `xfer_stb` and `tc` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 address, 1 count, 2 control, 3 unused |
| wr_data | input | 16 | Write data |
| req | input | 1 | Peripheral transfer request |
| grant | input | 1 | Bus grant; transfers happen only while high |
| eop_in | input | 1 | External end of process |
| xfer_addr | output | 16 | Current transfer address |
| xfer_stb | output | 1 | One transfer happens in this cycle |
| tc | output | 1 | Terminal count, high with the last transfer |

## Verification
The hardest case to reach from the ports is an external end of process that lands in the same cycle as a strobe in mid-burst. The transfer must still count, and what happens next depends on the reload setting. The stimulus starts a block burst on a 10-transfer program, raises `eop_in` exactly on the fourth strobe, and then shows that the channel ignores a new request. It then re-enables the channel and checks that the run resumes at the fifth address with six transfers left. A second case raises `eop_in` on the second strobe of a demand run with auto-reload and checks that the following run restarts from the base address with the full count.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [1:0] {
    MODE_DEMAND     = 2'b00,
    MODE_SINGLE     = 2'b01,
    MODE_BLOCK      = 2'b10,
    MODE_SINGLE_ALT = 2'b11
  } xfer_mode_e;

  // Control word layout, msb first: mode[4:3], auto_init[2], dir_down[1], enable[0]
  typedef struct packed {
    xfer_mode_e mode;
    logic       auto_init;
    logic       dir_down;
    logic       enable;
  } chan_ctrl_t;

  localparam int unsigned CTRL_W = $bits(chan_ctrl_t);

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_CNT  = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;

endpackage

// File: rtl/dma_req_ctrl.sv
module dma_req_ctrl
  import dma_chan_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  xfer_mode_e mode,
  input  logic       req,
  input  logic       grant,
  input  logic       proc_end,
  output logic       stb
);

  logic req_q, pend_q, burst_q;
  logic req_edge, is_single, pend_d, burst_d;

  // next-state logic
  always_comb begin
    req_edge  = req & ~req_q;
    is_single = (mode == MODE_SINGLE) || (mode == MODE_SINGLE_ALT);
    case (mode)
      MODE_DEMAND: stb = enable & grant & req;
      MODE_BLOCK:  stb = enable & grant & (burst_q | req_edge);
      default:     stb = enable & grant & (pend_q | req_edge);
    endcase
    pend_d  = enable & is_single & (pend_q | req_edge) & ~stb & ~proc_end;
    burst_d = enable & (mode == MODE_BLOCK) & (burst_q | req_edge) & ~proc_end;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      pend_q  <= 1'b0;
      burst_q <= 1'b0;
    end else begin
      req_q   <= req;
      pend_q  <= pend_d;
      burst_q <= burst_d;
    end
  end

  // R6: after a single-mode transfer, no second one until req has been low
  a_r6_single_one_per_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (is_single && stb) |=> (!stb || !$past(req) || (mode != $past(mode))));

  // R7: a running burst keeps transferring on every granted cycle
  a_r7_block_sustain: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_BLOCK && stb && !proc_end) |=>
      (!(enable && grant && mode == MODE_BLOCK) || stb));

endmodule

// File: rtl/dma_addr_cnt.sv
module dma_addr_cnt #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_addr,
  input  logic              wr_cnt,
  input  logic [ADDR_W-1:0] addr_data,
  input  logic [CNT_W-1:0]  cnt_data,
  input  logic              stb,
  input  logic              dir_down,
  input  logic              reload,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              last
);

  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
  localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);

  logic [ADDR_W-1:0] base_addr_q, cur_addr_q, cur_addr_d;
  logic [CNT_W-1:0]  base_cnt_q, cur_cnt_q, cur_cnt_d;
  logic              addr_ce, cnt_ce;

  // next-state logic: a write beats a reload, and a reload beats a step
  always_comb begin
    cur_addr_d = cur_addr_q;
    cur_cnt_d  = cur_cnt_q;
    if (wr_addr)     cur_addr_d = addr_data;
    else if (reload) cur_addr_d = base_addr_q;
    else if (stb)    cur_addr_d = dir_down ? (cur_addr_q - ADDR_ONE) : (cur_addr_q + ADDR_ONE);
    if (wr_cnt)      cur_cnt_d = cnt_data;
    else if (reload) cur_cnt_d = base_cnt_q;
    else if (stb)    cur_cnt_d = cur_cnt_q - CNT_ONE;
    addr_ce = wr_addr | reload | stb;
    cnt_ce  = wr_cnt  | reload | stb;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_addr_q <= '0;
      base_cnt_q  <= '0;
      cur_addr_q  <= '0;
      cur_cnt_q   <= '0;
    end else begin
      if (wr_addr) base_addr_q <= addr_data;
      if (wr_cnt)  base_cnt_q  <= cnt_data;
      if (addr_ce) cur_addr_q  <= cur_addr_d;
      if (cnt_ce)  cur_cnt_q   <= cur_cnt_d;
    end
  end

  assign cur_addr = cur_addr_q;
  assign last     = (cur_cnt_q == CNT_ONE);

  // R4: a plain transfer lowers the count by exactly one
  a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && !wr_cnt && !reload) |=> (cur_cnt_q == CNT_W'($past(cur_cnt_q) - CNT_ONE)));

  // R4: the address moves one step in the programmed direction
  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && !wr_addr && !reload) |=>
      (cur_addr_q == ($past(dir_down) ? ADDR_W'($past(cur_addr_q) - ADDR_ONE)
                                      : ADDR_W'($past(cur_addr_q) + ADDR_ONE))));

  // R10: a reload restores the base values
  a_r10_reload_base: assert property (@(posedge clk) disable iff (!rst_n)
    (reload && !wr_addr && !wr_cnt) |=>
      (cur_addr_q == base_addr_q && cur_cnt_q == base_cnt_q));

  // R1: a write sets base and current copies together
  a_r1_write_both: assert property (@(posedge clk) disable iff (!rst_n)
    wr_addr |=> (cur_addr_q == base_addr_q));

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_chan_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              req,
  input  logic              grant,
  input  logic              eop_in,
  output logic [ADDR_W-1:0] xfer_addr,
  output logic              xfer_stb,
  output logic              tc
);

  // asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  chan_ctrl_t ctrl_q, ctrl_d;
  logic       wr_addr, wr_cnt, wr_ctrl;
  logic       stb, last, proc_end, reload;

  always_comb begin
    wr_addr  = wr_en && (wr_sel == SEL_ADDR);
    wr_cnt   = wr_en && (wr_sel == SEL_CNT);
    wr_ctrl  = wr_en && (wr_sel == SEL_CTRL);
    proc_end = ctrl_q.enable & (eop_in | (stb & last));
    reload   = proc_end & ctrl_q.auto_init;
    ctrl_d   = ctrl_q;
    if (wr_ctrl)
      ctrl_d = chan_ctrl_t'(wr_data[CTRL_W-1:0]);
    else if (proc_end && !ctrl_q.auto_init)
      ctrl_d.enable = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) ctrl_q <= '0;
    else             ctrl_q <= ctrl_d;
  end

  dma_req_ctrl u_req (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .enable   (ctrl_q.enable),
    .mode     (ctrl_q.mode),
    .req      (req),
    .grant    (grant),
    .proc_end (proc_end),
    .stb      (stb)
  );

  dma_addr_cnt #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
  ) u_ac (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_addr   (wr_addr),
    .wr_cnt    (wr_cnt),
    .addr_data (wr_data[ADDR_W-1:0]),
    .cnt_data  (wr_data[CNT_W-1:0]),
    .stb       (stb),
    .dir_down  (ctrl_q.dir_down),
    .reload    (reload),
    .cur_addr  (xfer_addr),
    .last      (last)
  );

  assign xfer_stb = stb;
  assign tc       = stb & last;

  // R3: strobes only under grant on an enabled channel
  a_r3_stb_gated: assert property (@(posedge clk) disable iff (!rst_sync_n)
    xfer_stb |-> (grant && ctrl_q.enable));

  // R5: terminal count never stands alone
  a_r5_tc_with_stb: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tc |-> xfer_stb);

  // R11: end without reload leaves the channel quiet next cycle
  a_r11_end_disables: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (proc_end && !ctrl_q.auto_init && !wr_ctrl) |=> !xfer_stb);

  // R10: end with reload keeps the channel enabled
  a_r10_stays_enabled: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (proc_end && ctrl_q.auto_init && !wr_ctrl) |=> ctrl_q.enable);

endmodule

// File: tb/test_dma_chan_engine.sv
`timescale 1ns/100ps
module test_dma_chan_engine;

  logic        clk = 1'b0;
  logic        rst_n, wr_en, req, grant, eop_in;
  logic [1:0]  wr_sel;
  logic [15:0] wr_data, xfer_addr;
  logic        xfer_stb, tc;

  always #2.5 clk = ~clk;

  dma_chan_engine i_dma_chan_engine (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .req(req), .grant(grant), .eop_in(eop_in),
    .xfer_addr(xfer_addr), .xfer_stb(xfer_stb), .tc(tc)
  );

  typedef struct {
    logic [15:0] addr;
    logic        tc;
    string       tag;
  } exp_t;

  exp_t  sb_q[$];
  exp_t  got;
  string cur_tag = "R12";
  int    vectors = 0;
  int    miscompares = 0;
  bit    done = 1'b0;

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] data);
    wr_sel = sel; wr_data = data; wr_en = 1'b1;
    step();
    wr_en = 1'b0;
  endtask

  // driver side of the scoreboard: expected transfers of a run
  task automatic expect_run(input logic [15:0] start, input int n, input bit down,
                            input bit tc_end, input string tag);
    logic [15:0] a = start;
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.addr = a;
      e.tc   = tc_end && (i == n - 1);
      e.tag  = tag;
      sb_q.push_back(e);
      a = down ? a - 16'd1 : a + 16'd1;
    end
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drain(input string tag);
    repeat (3) step();
    vectors++;
    if (sb_q.size() != 0) begin
      miscompares++;
      $display("FAIL %s: actual=%0d transfers missing expected=0", tag, sb_q.size());
    end
    sb_q.delete();
  endtask

  // monitor side of the scoreboard
  always @(negedge clk) begin
    if (rst_n && xfer_stb) begin
      vectors++;
      if (sb_q.size() == 0) begin
        miscompares++;
        $display("FAIL %s: actual=strobe at %h expected=no strobe", cur_tag, xfer_addr);
      end else begin
        got = sb_q.pop_front();
        if (xfer_addr !== got.addr || tc !== got.tc) begin
          miscompares++;
          $display("FAIL %s: actual=%h/tc%b expected=%h/tc%b",
                   got.tag, xfer_addr, tc, got.addr, got.tc);
        end
      end
    end
    if (rst_n && tc && !xfer_stb) begin
      vectors++;
      miscompares++;
      $display("FAIL R5: actual=tc without strobe expected=no tc");
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 2'd0; wr_data = 16'h0;
    req = 1'b0; grant = 1'b0; eop_in = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();

    // R12: reset state, nothing moves on a request while disabled
    chk("R12 addr", xfer_addr, 16'h0000);
    chk("R12 stb", {15'd0, xfer_stb}, 16'd0);
    chk("R12 tc", {15'd0, tc}, 16'd0);
    grant = 1'b1; req = 1'b1; step(); req = 1'b0; step();
    grant = 1'b0;

    // R1, R6, R2: single mode, upward, count 3
    cur_tag = "R6";
    wr(2'd0, 16'h1000);
    chk("R1 addr load", xfer_addr, 16'h1000);
    wr(2'd1, 16'd3);
    wr(2'd2, 16'h0009);                  // enable, single (01)
    expect_run(16'h1000, 3, 1'b0, 1'b1, "R6");
    req = 1'b1; step(); req = 1'b0;
    chk("R3 no strobe without grant", {15'd0, xfer_stb}, 16'd0);
    step(); step();
    grant = 1'b1; step();               // pending request served here
    step(); step();
    chk("R6 one per edge", xfer_addr, 16'h1001);
    wr(2'd2, 16'h0019);                  // R2: mode 11 behaves as single
    req = 1'b1; step(); step(); step(); req = 1'b0; step();
    chk("R2 mode 11 single", xfer_addr, 16'h1002);
    req = 1'b1; step(); req = 1'b0; step();   // last one, tc, disable
    drain("R5");
    cur_tag = "R11";
    req = 1'b1; step(); req = 1'b0; step(); step();
    drain("R11");
    chk("R11 addr kept", xfer_addr, 16'h1003);

    // R8: demand mode with a pause, wrapping upward
    cur_tag = "R8";
    wr(2'd0, 16'hFFFE);
    wr(2'd1, 16'd5);
    wr(2'd2, 16'h0001);                  // enable, demand (00)
    expect_run(16'hFFFE, 5, 1'b0, 1'b1, "R8");
    req = 1'b1; step(); step(); req = 1'b0;
    step();
    chk("R8 pause stb", {15'd0, xfer_stb}, 16'd0);
    chk("R4 wrap up", xfer_addr, 16'h0000);
    step(); step();
    req = 1'b1; step(); step(); step(); req = 1'b0;
    drain("R8");

    // R7, R10, R4: block mode, downward, auto-reload
    cur_tag = "R7";
    wr(2'd0, 16'h0001);
    wr(2'd1, 16'd3);
    wr(2'd2, 16'h0017);                  // enable, down, reload, block (10)
    expect_run(16'h0001, 3, 1'b1, 1'b1, "R7");
    req = 1'b1; step(); req = 1'b0;
    repeat (4) step();
    drain("R7");
    chk("R10 addr reloaded", xfer_addr, 16'h0001);
    cur_tag = "R10";
    expect_run(16'h0001, 3, 1'b1, 1'b1, "R10");
    req = 1'b1; step(); req = 1'b0;
    repeat (4) step();
    drain("R10");

    // R9, R11: external end in mid-burst without reload
    cur_tag = "R9";
    wr(2'd0, 16'h0300);
    wr(2'd1, 16'd10);
    wr(2'd2, 16'h0011);                  // enable, block
    expect_run(16'h0300, 4, 1'b0, 1'b0, "R9");
    req = 1'b1; step(); req = 1'b0; step(); step();
    eop_in = 1'b1; step(); eop_in = 1'b0;
    step();
    drain("R9");
    chk("R9 last transfer counted", xfer_addr, 16'h0304);
    cur_tag = "R11";
    req = 1'b1; step(); req = 1'b0; step();
    drain("R11");
    cur_tag = "R9";
    wr(2'd2, 16'h0011);
    expect_run(16'h0304, 6, 1'b0, 1'b1, "R9 resume");
    req = 1'b1; step(); req = 1'b0;
    repeat (8) step();
    drain("R9");

    // R9, R10: external end in demand mode with reload
    cur_tag = "R10";
    wr(2'd0, 16'h0040);
    wr(2'd1, 16'd8);
    wr(2'd2, 16'h0005);                  // enable, reload, demand
    expect_run(16'h0040, 2, 1'b0, 1'b0, "R9 demand");
    req = 1'b1; step();
    eop_in = 1'b1; step();
    eop_in = 1'b0; req = 1'b0; step();
    drain("R9");
    chk("R10 reload after eop", xfer_addr, 16'h0040);
    expect_run(16'h0040, 8, 1'b0, 1'b1, "R10 full count");
    req = 1'b1;
    repeat (8) step();
    req = 1'b0;
    drain("R10");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule